// File: doc/BRIEF.md
# Three-Stage Subcarrier Phase Accumulator

This block produces the phase of a colour subcarrier from a fixed pixel clock. A coarse accumulator of 12 bits steps by an integer increment every clock and wraps at 4096. Its step is refined by two modular accumulators in a chain. The first correction accumulator counts in units of a programmable modulus and adds one extra count to the phase each time it overflows. The second correction accumulator has its own modulus and adds one extra count into the first on each overflow. The average phase advance per clock is therefore (step + (frac + fine/fine_mod) / frac_mod) / 4096 of a cycle. That ratio is exact, with no power-of-two rounding, so phase error does not build up over a long line or field.

The phase is brought back to zero on a programmable field cadence: every fourth field, every eighth field, or never. A downstream sine lookup uses the phase output. The lookup and the burst gating are not part of this block.

Top module: `sc_phase_dda`

## Requirements
- R1: While `rst` is high at a clock edge, all accumulators and the field counter clear, and `phase` reads 0 after that edge.
- R2: With only the coarse stage enabled, `phase` grows by `step_inc` each clock, modulo 4096.
- R3: With the coarse and fraction stages enabled, `phase` after n clocks since the last clear equals (n*step_inc + floor(n*frac_inc/frac_mod)) mod 4096, when frac_inc < frac_mod.
- R4: With all three stages enabled, the fraction stage also receives C = floor(n*fine_inc/fine_mod) extra counts. `phase` equals (n*step_inc + floor((n*frac_inc + C)/frac_mod)) mod 4096, when fine_inc < fine_mod.
- R5: A stage whose enable is low holds its accumulator and adds no increment and no carry. With `en_step` low the phase moves only by fraction carries. With `en_frac` low the fine stage's carries are ignored.
- R6: With `cad_mode` = 2'b01, a `field_start` pulse whose field count since reset is a multiple of 4 clears all accumulators on that clock, so `phase` is 0 after that edge. The first field after reset is count 0.
- R7: With `cad_mode` = 2'b10, only fields whose count is a multiple of 8 clear the accumulators.
- R8: With `cad_mode` = 2'b00 or 2'b11, no field ever clears the phase.
- R9: A `field_start` pulse on a field that is not due for a clear advances the phase exactly as a clock without the pulse would.
- R10: On every clock that is not a clear, the phase step is the enabled `step_inc` plus 0 or 1. It is exactly the enabled `step_inc` when `en_frac` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en_step | input | 1 | Coarse stage enable |
| en_frac | input | 1 | Fraction stage enable |
| en_fine | input | 1 | Fine correction stage enable |
| step_inc | input | 12 | Coarse increment per clock |
| frac_inc | input | 15 | Fraction increment per clock |
| frac_mod | input | 15 | Fraction modulus |
| fine_inc | input | 15 | Fine increment per clock |
| fine_mod | input | 15 | Fine modulus |
| cad_mode | input | 2 | Clear cadence: 00 never, 01 every 4 fields, 10 every 8, 11 never |
| field_start | input | 1 | One-clock pulse on the first clock of a field |
| phase | output | 12 | Registered subcarrier phase |

## Verification
The checker watches three things on every clock: the phase step stays within the enabled coarse increment plus at most one carry, a disabled fraction stage keeps its accumulator still, and a cadence clear always leaves the phase at zero without ever firing in a never mode. The exact rational long-run phase can only be shown by the bench's scenarios, which compare a closed-form floor expression over thousands of clocks. The same holds for the field count that decides which strobes clear, and for the way carries disappear when an upstream stage is disabled.

// File: rtl/sc_dda_pkg.sv
package sc_dda_pkg;
  typedef enum logic [1:0] {
    CAD_NEVER  = 2'b00,
    CAD_EVERY4 = 2'b01,
    CAD_EVERY8 = 2'b10,
    CAD_OFF    = 2'b11
  } cad_mode_e;
endpackage

// File: rtl/sc_dda_mod_acc.sv
// Modular accumulator: adds inc plus carry-in, subtracts the modulus once on overflow.
module sc_dda_mod_acc #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] inc,
  input  logic [W-1:0] modulus,
  input  logic         cin,
  output logic [W-1:0] acc,
  output logic         cout
);
  logic [W:0] sum;
  logic [W:0] nxt;

  always_comb begin
    sum  = {1'b0, acc} + {1'b0, inc} + {{W{1'b0}}, cin};
    cout = en && (sum >= {1'b0, modulus});
    nxt  = cout ? (sum - {1'b0, modulus}) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= nxt[W-1:0];
  end
endmodule

// File: rtl/sc_dda_phase_acc.sv
// Coarse phase register, wraps at 2**PW.
module sc_dda_phase_acc #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [PW-1:0] inc,
  input  logic          cin,
  output logic [PW-1:0] phase
);
  logic [PW-1:0] step;

  always_comb step = (en ? inc : '0) + {{(PW-1){1'b0}}, cin};

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= '0;
    else            phase <= phase + step;
  end
endmodule

// File: rtl/sc_dda_cadence.sv
// Field counter deciding which field starts clear the accumulators.
module sc_dda_cadence
  import sc_dda_pkg::*;
#(
  parameter int LONG_PERIOD = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       field_start,
  output logic       clr
);
  localparam int CW = $clog2(LONG_PERIOD);
  localparam int SW = CW - 1;

  logic [CW-1:0] fcnt;
  logic          due;

  always_comb begin
    case (cad_mode_e'(mode))
      CAD_EVERY4: due = (fcnt[SW-1:0] == '0);
      CAD_EVERY8: due = (fcnt == '0);
      default:    due = 1'b0;
    endcase
    clr = field_start && due;
  end

  always_ff @(posedge clk) begin
    if (rst)              fcnt <= '0;
    else if (field_start) fcnt <= fcnt + 1'b1;
  end
endmodule

// File: rtl/sc_phase_dda.sv
module sc_phase_dda
  import sc_dda_pkg::*;
#(
  parameter int PHASE_W     = 12,
  parameter int FRAC_W      = 15,
  parameter int NUM_CORR    = 2,
  parameter int LONG_PERIOD = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_step,
  input  logic               en_frac,
  input  logic               en_fine,
  input  logic [PHASE_W-1:0] step_inc,
  input  logic [FRAC_W-1:0]  frac_inc,
  input  logic [FRAC_W-1:0]  frac_mod,
  input  logic [FRAC_W-1:0]  fine_inc,
  input  logic [FRAC_W-1:0]  fine_mod,
  input  logic [1:0]         cad_mode,
  input  logic               field_start,
  output logic [PHASE_W-1:0] phase
);
  // Correction chain index 0 is the finest stage; the last one feeds the phase.
  logic [FRAC_W-1:0] c_inc [NUM_CORR];
  logic [FRAC_W-1:0] c_mod [NUM_CORR];
  logic              c_en  [NUM_CORR];
  logic [FRAC_W-1:0] c_acc [NUM_CORR];
  logic              carry [NUM_CORR+1];
  logic              field_clr;
  logic [FRAC_W-1:0] frac2_acc;

  always_comb begin
    c_inc[0] = fine_inc;
    c_mod[0] = fine_mod;
    c_en[0]  = en_fine;
    c_inc[NUM_CORR-1] = frac_inc;
    c_mod[NUM_CORR-1] = frac_mod;
    c_en[NUM_CORR-1]  = en_frac;
  end

  assign carry[0]  = 1'b0;
  assign frac2_acc = c_acc[NUM_CORR-1];

  sc_dda_cadence #(.LONG_PERIOD(LONG_PERIOD)) u_cad (
    .clk(clk), .rst(rst), .mode(cad_mode),
    .field_start(field_start), .clr(field_clr)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CORR; g++) begin : g_corr
      sc_dda_mod_acc #(.W(FRAC_W)) u_stage (
        .clk(clk), .rst(rst), .clr(field_clr), .en(c_en[g]),
        .inc(c_inc[g]), .modulus(c_mod[g]), .cin(carry[g]),
        .acc(c_acc[g]), .cout(carry[g+1])
      );
    end
  endgenerate

  sc_dda_phase_acc #(.PW(PHASE_W)) u_phase (
    .clk(clk), .rst(rst), .clr(field_clr), .en(en_step),
    .inc(step_inc), .cin(carry[NUM_CORR]), .phase(phase)
  );
endmodule

// File: rtl/sc_dda_checker.sv
module sc_dda_checker #(
  parameter int PHASE_W = 12,
  parameter int FRAC_W  = 15
) (
  input logic               clk,
  input logic               rst,
  input logic               en_step,
  input logic               en_frac,
  input logic [PHASE_W-1:0] step_inc,
  input logic [1:0]         cad_mode,
  input logic               field_start,
  input logic               field_clr,
  input logic [FRAC_W-1:0]  frac2_acc,
  input logic [PHASE_W-1:0] phase
);
  typedef logic [PHASE_W-1:0] ph_t;

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (phase == '0));

  assert_step_bound_R10: assert property (@(posedge clk) disable iff (rst)
    !field_clr |=> (ph_t'(phase - $past(phase) - ($past(en_step) ? $past(step_inc) : '0)) <= ph_t'(1)));

  assert_exact_step_R10: assert property (@(posedge clk) disable iff (rst)
    (!field_clr && !en_frac) |=> (phase == ph_t'($past(phase) + ($past(en_step) ? $past(step_inc) : '0))));

  assert_frac_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!en_frac && !field_clr) |=> $stable(frac2_acc));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    field_clr |=> (phase == '0 && frac2_acc == '0));

  assert_never_mode_R8: assert property (@(posedge clk) disable iff (rst)
    (field_start && (cad_mode == 2'b00 || cad_mode == 2'b11)) |-> !field_clr);
endmodule

bind sc_phase_dda sc_dda_checker #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .en_step(en_step), .en_frac(en_frac),
  .step_inc(step_inc), .cad_mode(cad_mode), .field_start(field_start),
  .field_clr(field_clr), .frac2_acc(frac2_acc), .phase(phase)
);

// File: tb/tb_sc_phase_dda.sv
module tb_sc_phase_dda;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_step = 1'b0, en_frac = 1'b0, en_fine = 1'b0;
  logic [11:0] step_inc = '0;
  logic [14:0] frac_inc = '0, frac_mod = 15'd1, fine_inc = '0, fine_mod = 15'd1;
  logic [1:0]  cad_mode = 2'b00;
  logic        field_start = 1'b0;
  logic [11:0] phase;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_phase_dda dut (
    .clk(clk), .rst(rst), .en_step(en_step), .en_frac(en_frac), .en_fine(en_fine),
    .step_inc(step_inc), .frac_inc(frac_inc), .frac_mod(frac_mod),
    .fine_inc(fine_inc), .fine_mod(fine_mod), .cad_mode(cad_mode),
    .field_start(field_start), .phase(phase)
  );

  // Closed-form rational reference for n clocks since the last clear.
  function automatic int exp_phase(longint n);
    longint c3, c2, s1;
    c3 = (en_fine && en_frac) ? (n * longint'(fine_inc)) / longint'(fine_mod) : 0;
    c2 = en_frac ? (n * longint'(frac_inc) + c3) / longint'(frac_mod) : 0;
    s1 = en_step ? n * longint'(step_inc) : 0;
    return int'((s1 + c2) % 4096);
  endfunction

  function automatic bit field_due(int fc, logic [1:0] m);
    if (m == 2'b01) return (fc % 4) == 0;
    if (m == 2'b10) return (fc % 8) == 0;
    return 1'b0;
  endfunction

  task automatic check(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: phase actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    field_start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", int'(phase), 0);
    rst = 1'b0;
  endtask

  // Runs ncyc clocks; fper > 0 pulses field_start every fper clocks.
  task automatic run(string tag, int ncyc, int fper);
    longint n = 0;
    int fc = 0;
    do_reset();
    for (int k = 0; k < ncyc; k++) begin
      bit fs;
      bit clr_now;
      string t;
      fs = (fper > 0) && ((k % fper) == fper - 1);
      field_start = fs;
      @(posedge clk);
      @(negedge clk);
      field_start = 1'b0;
      t = tag;
      clr_now = fs && field_due(fc, cad_mode);
      if (fs) begin
        if (!clr_now && (cad_mode == 2'b01 || cad_mode == 2'b10)) t = "R9";
        fc++;
      end
      if (clr_now) n = 0;
      else n++;
      check(t, int'(phase), exp_phase(n));
    end
  endtask

  task automatic cfg(bit e1, bit e2, bit e3, int i1, int i2, int m2, int i3, int m3, logic [1:0] md);
    en_step = e1; en_frac = e2; en_fine = e3;
    step_inc = 12'(i1); frac_inc = 15'(i2); frac_mod = 15'(m2);
    fine_inc = 15'(i3); fine_mod = 15'(m3); cad_mode = md;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5C0DDA));
    // R1 during reset
    @(negedge clk);
    @(negedge clk);
    check("R1", int'(phase), 0);
    // R2: coarse stage only, wrap with the largest step
    cfg(1, 0, 0, 4095, 0, 1, 0, 1, 2'b00); run("R2", 600, 0);
    cfg(1, 0, 0, 136, 0, 1, 0, 1, 2'b00);  run("R2", 600, 0);
    // R3: coarse + fraction, standard NTSC-like setting
    cfg(1, 1, 0, 136, 7624, 20013, 0, 1, 2'b00); run("R3", 4000, 0);
    // R4: all three stages
    cfg(1, 1, 1, 168, 4093, 27456, 310, 525, 2'b00); run("R4", 4000, 0);
    cfg(1, 1, 1, 135, 29998, 29999, 29998, 29999, 2'b00); run("R4", 3000, 0);
    // R5: coarse disabled, only fraction carries move the phase
    cfg(0, 1, 1, 999, 23578, 27648, 134, 625, 2'b00); run("R5", 3000, 0);
    // R5: fraction disabled, fine carries are ignored
    cfg(1, 0, 1, 77, 5000, 6000, 400, 401, 2'b00); run("R5", 1500, 0);
    // R6/R7/R8 cadence with field pulses
    cfg(1, 1, 1, 168, 4122, 27648, 67, 625, 2'b01); run("R6", 4000, 97);
    cfg(1, 1, 0, 136, 5611, 26250, 0, 1, 2'b10);    run("R7", 5000, 113);
    cfg(1, 1, 1, 136, 12056, 26250, 5, 9, 2'b00);   run("R8", 3000, 71);
    cfg(1, 1, 1, 168, 18557, 20625, 3, 7, 2'b11);   run("R8", 3000, 59);
    // Constrained random configurations
    for (int r = 0; r < 12; r++) begin
      int m2, m3;
      m2 = 1000 + int'($urandom % 29000);
      m3 = 2 + int'($urandom % 29990);
      cfg(1'($urandom), 1, 1'($urandom), int'($urandom % 4096), int'($urandom % m2), m2,
          int'($urandom % m3), m3, 2'($urandom));
      run("R4", 2500, 40 + int'($urandom % 200));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule